// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Controller

This block runs one bulk or interrupt IN endpoint with two alternating data banks. Firmware writes packet bytes into the bank it owns. A transmit-ready command then hands that bank to the bus side. The firmware write target moves to the other bank at once, so the next packet can be written while the first waits for the host's IN token.

The bus side sees abstract events: an IN token, a host ACK and a timeout. For each IN token it answers with NAK or with data. A data answer carries a byte count and the current data toggle, followed by the bytes, one per cycle. When the host ACKs a packet, the bank goes back to firmware, the toggle flips and a completion flag is raised, which can drive an interrupt. After a timeout the same packet is sent again, unchanged.

Packet encoding, CRC, bit stuffing and the serial engine are outside this block.

Top module: `usb_in_pingpong_ep`

## Requirements
- R1: While `ep_enable_i` or `ep_config_i` is low, an IN token produces no response (`resp_valid_o` stays 0). This holds even when a bank is ready.
- R2: `fw_bank_o` starts at 0. It switches to the other bank one cycle after a transmit-ready command on a bank the firmware owns.
- R3: If an IN token arrives and the next bank to send is not ready, `resp_valid_o`=1 with `resp_data_o`=0 (NAK) for one cycle, starting the cycle after the token.
- R4: If an IN token arrives and a bank is ready, the cycle after the token shows `resp_valid_o`=1 and `resp_data_o`=1, with `pkt_len_o` equal to the bank's byte count and `pkt_toggle_o` equal to the toggle (0 = DATA0, 1 = DATA1). Bytes appear on `tx_byte_o` with `tx_valid_o`=1 in write order, one per cycle, starting in that same cycle, and `tx_last_o` marks the final byte. A zero-length packet sends no bytes.
- R5: Ready banks are sent in the order they were released, oldest first.
- R6: An ACK after a data packet does four things: it returns the bank to firmware with a count of zero, flips the toggle, moves to the other bank, and raises `txcmpl_o` on the next cycle.
- R7: A timeout after a data packet keeps the bank, the count and the toggle. The next IN token resends the same packet, and `txcmpl_o` is not raised.
- R8: `txcmpl_o` shows the oldest completion still pending. A clear command removes only that one completion, so two pending completions need two clears.
- R9: `irq_o` is 1 exactly when `irq_enable_i` is 1 and `txcmpl_o` is 1.
- R10: A write is dropped if it would go beyond `BANK_BYTES`, or if it targets a bank owned by the bus side. A dropped write sets the sticky flag `ovfl_o`. A dropped write does not change the stored packet.
- R11: Reset clears all byte counts, the ready and completion flags, both bank pointers and `ovfl_o`, and selects DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_enable_i | input | 1 | Endpoint enabled |
| ep_config_i | input | 1 | Endpoint configured |
| irq_enable_i | input | 1 | Completion interrupt enable |
| fw_wr_i | input | 1 | Firmware byte write strobe |
| fw_wdata_i | input | DATA_W | Firmware write byte |
| fw_txrdy_i | input | 1 | Release the current write bank for sending |
| fw_txclr_i | input | 1 | Clear the oldest pending completion |
| tok_in_i | input | 1 | IN token for this endpoint |
| tok_ack_i | input | 1 | Host ACK for the packet just sent |
| tok_timeout_i | input | 1 | No handshake from the host |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_data_o | output | 1 | 1 = data packet, 0 = NAK |
| pkt_len_o | output | CNT_W | Byte count of the packet being sent |
| pkt_toggle_o | output | 1 | Data toggle, 0 = DATA0 |
| tx_valid_o | output | 1 | Packet byte valid |
| tx_byte_o | output | DATA_W | Packet byte |
| tx_last_o | output | 1 | Final byte of the packet |
| txcmpl_o | output | 1 | Oldest pending completion |
| irq_o | output | 1 | Interrupt |
| ovfl_o | output | 1 | Sticky dropped-write flag |
| fw_bank_o | output | 1 | Bank that firmware writes next |

## Verification
A response and the first byte are due one cycle after the clock edge that samples the IN token. Byte i follows i cycles after that. The sending state ends one cycle after the last byte, and only then is a handshake accepted. `txcmpl_o` and `fw_bank_o` change one cycle after the ACK or the command that moves them, and `irq_o` follows `txcmpl_o` in the same cycle. The bench drives every input just after a falling edge and samples at the next falling edge. Each check therefore sees the state after exactly the counted number of rising edges.

// File: rtl/usb_inep_pkg.sv
package usb_inep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } bus_st_e;
endpackage

// File: rtl/usb_inep_bank_store.sv
module usb_inep_bank_store #(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 7,
  parameter int ADDR_W     = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       wr_bank_i,
  input  logic [1:0]                 ready_i,
  input  logic                       free_i,
  input  logic                       free_bank_i,
  input  logic                       rd_bank_i,
  input  logic [ADDR_W-1:0]          rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [1:0][CNT_W-1:0]      cnt_o,
  output logic                       ovfl_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BANK_BYTES);

  logic [1:0]             wr_ok;
  logic [1:0][DATA_W-1:0] rd_word;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_BYTES];
    logic [CNT_W-1:0]  cnt_q;

    assign wr_ok[b] = wr_i && (wr_bank_i == 1'(b)) && !ready_i[b] && (cnt_q < CAP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (free_i && (free_bank_i == 1'(b))) begin
        cnt_q <= '0;
      end else if (wr_ok[b]) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_ok[b]) mem[cnt_q[ADDR_W-1:0]] <= wdata_i;
    end

    assign rd_word[b] = mem[rd_idx_i];
    assign cnt_o[b]   = cnt_q;
  end

  assign rd_data_o = rd_word[rd_bank_i];

  // any rejected write is sticky
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovfl_o <= 1'b0;
    else if (wr_i && ~|wr_ok)   ovfl_o <= 1'b1;
  end
endmodule

// File: rtl/usb_inep_flags.sv
module usb_inep_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txrdy_i,
  input  logic       clr_i,
  input  logic       ack_i,
  input  logic       ack_bank_i,
  output logic [1:0] ready_o,
  output logic [1:0] done_o,
  output logic       fw_bank_o,
  output logic       txcmpl_o
);
  logic clr_ptr_q;
  logic release_ok;
  logic clear_ok;

  assign release_ok = txrdy_i && !ready_o[fw_bank_o];
  assign clear_ok   = clr_i && done_o[clr_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw_bank_o <= 1'b0;
      clr_ptr_q <= 1'b0;
    end else begin
      if (release_ok) fw_bank_o <= ~fw_bank_o;
      if (clear_ok)   clr_ptr_q <= ~clr_ptr_q;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_o[b] <= 1'b0;
        done_o[b]  <= 1'b0;
      end else begin
        if (release_ok && fw_bank_o == 1'(b))    ready_o[b] <= 1'b1;
        else if (ack_i && ack_bank_i == 1'(b))   ready_o[b] <= 1'b0;
        // a new completion wins over a clear of the same bank
        if (ack_i && ack_bank_i == 1'(b))        done_o[b]  <= 1'b1;
        else if (clear_ok && clr_ptr_q == 1'(b)) done_o[b]  <= 1'b0;
      end
    end
  end

  assign txcmpl_o = done_o[clr_ptr_q];
endmodule

// File: rtl/usb_inep_bus_fsm.sv
module usb_inep_bus_fsm
  import usb_inep_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  cfg_i,
  input  logic                  tok_in_i,
  input  logic                  tok_ack_i,
  input  logic                  tok_timeout_i,
  input  logic [1:0]            ready_i,
  input  logic [1:0][CNT_W-1:0] cnt_i,
  output logic                  resp_valid_o,
  output logic                  resp_data_o,
  output logic [CNT_W-1:0]      pkt_len_o,
  output logic                  toggle_o,
  output logic                  tx_valid_o,
  output logic                  tx_last_o,
  output logic [ADDR_W-1:0]     rd_idx_o,
  output logic                  tx_bank_o,
  output logic                  ack_o,
  output logic                  wait_o
);
  bus_st_e          st_q;
  logic [CNT_W-1:0] idx_q;
  logic             at_last;

  assign at_last = (idx_q + 1'b1) == pkt_len_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      pkt_len_o    <= '0;
      toggle_o     <= 1'b0;
      tx_bank_o    <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_data_o  <= 1'b0;
    end else begin
      resp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (tok_in_i && en_i && cfg_i) begin
            resp_valid_o <= 1'b1;
            if (ready_i[tx_bank_o]) begin
              resp_data_o <= 1'b1;
              pkt_len_o   <= cnt_i[tx_bank_o];
              idx_q       <= '0;
              st_q        <= (cnt_i[tx_bank_o] == '0) ? ST_WAIT : ST_SEND;
            end else begin
              resp_data_o <= 1'b0;
            end
          end
        end
        ST_SEND: begin
          if (at_last) st_q  <= ST_WAIT;
          else         idx_q <= idx_q + 1'b1;
        end
        ST_WAIT: begin
          if (tok_ack_i) begin
            toggle_o  <= ~toggle_o;
            tx_bank_o <= ~tx_bank_o;
            st_q      <= ST_IDLE;
          end else if (tok_timeout_i) begin
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (st_q == ST_SEND);
  assign tx_last_o  = tx_valid_o && at_last;
  assign rd_idx_o   = idx_q[ADDR_W-1:0];
  assign wait_o     = (st_q == ST_WAIT);
  assign ack_o      = wait_o && tok_ack_i;
endmodule

// File: rtl/usb_in_pingpong_ep.sv
module usb_in_pingpong_ep #(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep_enable_i,
  input  logic              ep_config_i,
  input  logic              irq_enable_i,
  input  logic              fw_wr_i,
  input  logic [DATA_W-1:0] fw_wdata_i,
  input  logic              fw_txrdy_i,
  input  logic              fw_txclr_i,
  input  logic              tok_in_i,
  input  logic              tok_ack_i,
  input  logic              tok_timeout_i,
  output logic              resp_valid_o,
  output logic              resp_data_o,
  output logic [CNT_W-1:0]  pkt_len_o,
  output logic              pkt_toggle_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_last_o,
  output logic              txcmpl_o,
  output logic              irq_o,
  output logic              ovfl_o,
  output logic              fw_bank_o
);
  localparam int ADDR_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;

  logic [1:0]            ready;
  logic [1:0]            done;
  logic [1:0][CNT_W-1:0] cnt;
  logic                  ack;
  logic                  tx_bank;
  logic                  bus_wait;
  logic [ADDR_W-1:0]     rd_idx;

  usb_inep_bank_store #(
    .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_i        (fw_wr_i),
    .wdata_i     (fw_wdata_i),
    .wr_bank_i   (fw_bank_o),
    .ready_i     (ready),
    .free_i      (ack),
    .free_bank_i (tx_bank),
    .rd_bank_i   (tx_bank),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (tx_byte_o),
    .cnt_o       (cnt),
    .ovfl_o      (ovfl_o)
  );

  usb_inep_flags u_flags (
    .clk_i, .rst_ni,
    .txrdy_i    (fw_txrdy_i),
    .clr_i      (fw_txclr_i),
    .ack_i      (ack),
    .ack_bank_i (tx_bank),
    .ready_o    (ready),
    .done_o     (done),
    .fw_bank_o  (fw_bank_o),
    .txcmpl_o   (txcmpl_o)
  );

  usb_inep_bus_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .en_i          (ep_enable_i),
    .cfg_i         (ep_config_i),
    .tok_in_i      (tok_in_i),
    .tok_ack_i     (tok_ack_i),
    .tok_timeout_i (tok_timeout_i),
    .ready_i       (ready),
    .cnt_i         (cnt),
    .resp_valid_o  (resp_valid_o),
    .resp_data_o   (resp_data_o),
    .pkt_len_o     (pkt_len_o),
    .toggle_o      (pkt_toggle_o),
    .tx_valid_o    (tx_valid_o),
    .tx_last_o     (tx_last_o),
    .rd_idx_o      (rd_idx),
    .tx_bank_o     (tx_bank),
    .ack_o         (ack),
    .wait_o        (bus_wait)
  );

  assign irq_o = irq_enable_i & txcmpl_o;
endmodule

// File: rtl/usb_inep_checker.sv
module usb_inep_checker #(
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ep_enable_i,
  input logic             ep_config_i,
  input logic             irq_enable_i,
  input logic             fw_txrdy_i,
  input logic             tok_in_i,
  input logic             tok_ack_i,
  input logic             tok_timeout_i,
  input logic             resp_valid_o,
  input logic [CNT_W-1:0] pkt_len_o,
  input logic             pkt_toggle_o,
  input logic             irq_o,
  input logic             ovfl_o,
  input logic             fw_bank_o,
  input logic [1:0]       ready,
  input logic             tx_valid_o,
  input logic             bus_wait
);
  AST_SILENT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_in_i && !(ep_enable_i && ep_config_i) && !tx_valid_o && !bus_wait |=> !resp_valid_o); // R1
  AST_BANK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_txrdy_i && !ready[fw_bank_o] |=> fw_bank_o != $past(fw_bank_o)); // R2
  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R3
  AST_TOGGLE_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pkt_toggle_o) |-> $past(tok_ack_i)); // R6
  AST_RETRY_KEEPS_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wait && tok_timeout_i && !tok_ack_i |=> $stable(pkt_toggle_o)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_enable_i); // R9
  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_len_o <= CNT_W'(BANK_BYTES)); // R10
  AST_OVFL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovfl_o |=> ovfl_o); // R10
endmodule

bind usb_in_pingpong_ep usb_inep_checker #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ep_enable_i(ep_enable_i), .ep_config_i(ep_config_i),
  .irq_enable_i(irq_enable_i), .fw_txrdy_i(fw_txrdy_i), .tok_in_i(tok_in_i),
  .tok_ack_i(tok_ack_i), .tok_timeout_i(tok_timeout_i), .resp_valid_o(resp_valid_o),
  .pkt_len_o(pkt_len_o), .pkt_toggle_o(pkt_toggle_o), .irq_o(irq_o), .ovfl_o(ovfl_o),
  .fw_bank_o(fw_bank_o), .ready(ready), .tx_valid_o(tx_valid_o), .bus_wait(bus_wait)
);

// File: tb/tb_usb_in_pingpong_ep.sv
`timescale 1ns/1ps
module tb_usb_in_pingpong_ep;
  localparam int BANK = 64;
  localparam int CW   = $clog2(BANK + 1);

  logic clk_i = 0, rst_ni = 0;
  logic ep_enable_i = 0, ep_config_i = 0, irq_enable_i = 0;
  logic fw_wr_i = 0, fw_txrdy_i = 0, fw_txclr_i = 0;
  logic [7:0] fw_wdata_i = '0;
  logic tok_in_i = 0, tok_ack_i = 0, tok_timeout_i = 0;
  logic resp_valid_o, resp_data_o, pkt_toggle_o, tx_valid_o, tx_last_o;
  logic txcmpl_o, irq_o, ovfl_o, fw_bank_o;
  logic [CW-1:0] pkt_len_o;
  logic [7:0] tx_byte_o;

  int nvec = 0, nerr = 0;
  bit tog = 0;

  always #2 clk_i = ~clk_i;

  usb_in_pingpong_ep #(.BANK_BYTES(BANK)) dut (.*);

  function automatic int byte_of(int seed, int i);
    return (seed * 37 + i * 5 + 1) & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic fill(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); fw_wr_i = 1; fw_wdata_i = 8'(byte_of(seed, i));
    end
    @(negedge clk_i); fw_wr_i = 0; fw_txrdy_i = 1;
    @(negedge clk_i); fw_txrdy_i = 0;
  endtask

  task automatic token_expect(bit exp_valid, string req);
    @(negedge clk_i); tok_in_i = 1;
    @(negedge clk_i); tok_in_i = 0;
    chk(req, resp_valid_o, exp_valid);
    if (exp_valid) chk(req, resp_data_o, 0);
    @(negedge clk_i);
    chk(req, resp_valid_o, 0);
  endtask

  task automatic send(int len, int seed, bit ack);
    @(negedge clk_i); tok_in_i = 1;
    @(negedge clk_i); tok_in_i = 0;
    chk("R4 resp_valid", resp_valid_o, 1);
    chk("R4 resp_data", resp_data_o, 1);
    chk("R4 pkt_len", pkt_len_o, len);
    chk("R4 toggle", pkt_toggle_o, tog);
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk_i);
      chk("R4 tx_valid", tx_valid_o, 1);
      chk("R5 tx_byte", tx_byte_o, byte_of(seed, i));
      chk("R4 tx_last", tx_last_o, i == len - 1);
    end
    @(negedge clk_i);
    chk("R4 tx_valid end", tx_valid_o, 0);
    if (ack) tok_ack_i = 1; else tok_timeout_i = 1;
    @(negedge clk_i); tok_ack_i = 0; tok_timeout_i = 0;
    if (ack) tog = ~tog;
  endtask

  task automatic clear_one();
    @(negedge clk_i); fw_txclr_i = 1;
    @(negedge clk_i); fw_txclr_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    // R11 reset state
    chk("R11 resp_valid", resp_valid_o, 0);
    chk("R11 tx_valid", tx_valid_o, 0);
    chk("R11 txcmpl", txcmpl_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 ovfl", ovfl_o, 0);
    chk("R11 toggle", pkt_toggle_o, 0);
    chk("R11 fw_bank", fw_bank_o, 0);

    ep_enable_i = 1; ep_config_i = 1;
    token_expect(1, "R3 nak empty");
    ep_enable_i = 0; ep_config_i = 0;

    fill(0, 0);
    chk("R2 fw_bank after release", fw_bank_o, 1);
    fill(1, 1);
    chk("R2 fw_bank wraps", fw_bank_o, 0);
    token_expect(0, "R1 disabled");
    ep_enable_i = 1;
    token_expect(0, "R1 unconfigured");
    ep_config_i = 1;

    for (int k = 0; k <= BANK; k++) begin
      irq_enable_i = (k % 3) != 0;
      if (k == 5) begin
        send(k, k, 0);
        chk("R7 no completion on timeout", txcmpl_o, 0);
      end
      send(k, k, 1);
      chk("R6 txcmpl after ack", txcmpl_o, 1);
      chk("R9 irq", irq_o, irq_enable_i);
      clear_one();
      chk("R8 txcmpl cleared", txcmpl_o, 0);
      chk("R9 irq after clear", irq_o, 0);
      if (k + 2 <= BANK) begin
        chk("R2 fw_bank before fill", fw_bank_o, k % 2);
        fill(k + 2, k + 2);
      end
    end
    token_expect(1, "R3 nak drained");

    // R8: two pending completions need two clears
    irq_enable_i = 1;
    fill(4, 100);
    fill(6, 101);
    send(4, 100, 1);
    send(6, 101, 1);
    chk("R8 two pending", txcmpl_o, 1);
    clear_one();
    chk("R8 one left", txcmpl_o, 1);
    chk("R9 irq one left", irq_o, 1);
    clear_one();
    chk("R8 none left", txcmpl_o, 0);

    // R10: write into a bank owned by the bus side is dropped
    fill(2, 102);
    fill(3, 103);
    chk("R10 ovfl clean", ovfl_o, 0);
    @(negedge clk_i); fw_wr_i = 1; fw_wdata_i = 8'hEE;
    @(negedge clk_i); fw_wr_i = 0;
    chk("R10 ovfl owned bank", ovfl_o, 1);
    send(2, 102, 1);
    clear_one();
    send(3, 103, 1);
    clear_one();

    // R10: write past capacity is dropped
    fill(BANK + 1, 104);
    chk("R10 ovfl sticky", ovfl_o, 1);
    send(BANK, 104, 1);
    chk("R6 final completion", txcmpl_o, 1);
    clear_one();

    summary();
  end
endmodule